// File: doc/BRIEF.md
# Noise-Shaped Two-Segment DAC Splitter

This block divides each 6-bit sample from a multi-bit modulator between two unit-element DACs of unequal weight. A coarse DAC with elements worth four least-significant steps takes a 4-bit coarse count. A fine DAC with elements worth one step takes the remainder. The sum of the two segment contributions always equals the input sample exactly.

The coarse count is not simply the upper bits of the sample. A first-order digital requantizer with a 2-bit error accumulator chooses it, so both segment streams carry first-order shaped requantization noise. As a result, a gain mismatch between the two DACs shows up as shaped noise rather than as distortion. The residual is offset so that it sits in the middle of its 0..7 range. This means that across most of the input span the residual never has to be clamped.

Both counts leave the block as thermometer vectors, one line per DAC element, from registers that load only on accepted samples. Element scrambling and the DACs themselves sit downstream.

Top module: `seg_dac_splitter`

## Requirements
- R1: A synchronous active-high `rst` clears the error accumulator and both output vectors to all zeros. The first accepted sample after reset is processed with an accumulator of 0.
- R2: A sample presented with `in_valid` high at a rising clock edge appears on both output vectors right after that edge. The outputs do not change before that edge.
- R3: While `in_valid` is low, `in_code` is ignored: both output vectors and the accumulator keep their values.
- R4: For every accepted sample, 4 × (number of ones in `coarse_therm`) + (number of ones in `fine_therm`) equals that sample's `in_code`.
- R5: `coarse_therm` is a thermometer code filled from bit 0 upward: bits 0..C-1 are high and all other bits are low, where C is the coarse count (0..15). Bit 15 is therefore never high.
- R6: `fine_therm` is a thermometer code filled from bit 0 upward: bits 0..F-1 are high and all other bits are low, where F is the fine count (0..7). Bit 7 is therefore never high.
- R7: Let A be the accumulator (0..3) and S = `in_code` + A − 3. Then C = floor(S / 4) when S ≥ 0, and C = 0 when S < 0.
- R8: On each accepted sample the accumulator becomes S − 4 × C when S ≥ 0, and 0 when S < 0.
- R9: For a constant `in_code` x ≥ 3, any four consecutive accepted samples have coarse counts that sum to x − 3 and fine counts that sum to 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_code` at this edge |
| in_code | input | 6 | Modulator sample, unsigned 0..63 |
| coarse_therm | output | 16 | Thermometer lines for the 4X-weighted elements |
| fine_therm | output | 8 | Thermometer lines for the 1X-weighted elements |

## Verification
Every result is due exactly one rising edge after the edge that accepts the sample, and a rejected sample must leave the outputs unchanged through that edge. The bench drives each sample on a falling edge. Two nanoseconds later, still before the accepting edge, it confirms the outputs still show the previous result. One nanosecond after the rising edge it compares the new vectors with the values from its own requantizer model. The four-sample averaging property is checked on counts taken at those same post-edge instants during constant-input runs.

// File: rtl/seg_dac_splitter_pkg.sv
package seg_dac_splitter_pkg;
    // Default geometry: 6-bit samples, coarse weight 2**2 = 4
    localparam int DEF_IN_W     = 6;
    localparam int DEF_SEG_BITS = 2;
endpackage

// File: rtl/seg_dac_requant.sv
// First-order requantizer: picks the coarse count and the fine residual
// from one sample and the current error accumulator (combinational).
module seg_dac_requant #(
    parameter int IN_W     = seg_dac_splitter_pkg::DEF_IN_W,
    parameter int SEG_BITS = seg_dac_splitter_pkg::DEF_SEG_BITS
) (
    input  logic [IN_W-1:0]          sample,
    input  logic [SEG_BITS-1:0]      acc_q,
    output logic [IN_W-SEG_BITS-1:0] coarse_n,
    output logic [SEG_BITS:0]        fine_n,
    output logic [SEG_BITS-1:0]      acc_d
);
    localparam int CW  = IN_W - SEG_BITS;
    localparam int SW  = IN_W + 1;                // room for a negative sum
    localparam int OFS = (1 << SEG_BITS) - 1;     // centres the residual

    logic [SW-1:0] sum_s;

    always_comb begin
        sum_s = {1'b0, sample} + {{(SW-SEG_BITS){1'b0}}, acc_q} - SW'(OFS);
        if (sum_s[SW-1]) begin
            coarse_n = '0;
            acc_d    = '0;
        end else begin
            coarse_n = sum_s[SEG_BITS +: CW];
            acc_d    = sum_s[SEG_BITS-1:0];
        end
        // residual lies in 0..2*OFS+1, so modular low-bit arithmetic is exact
        fine_n = sample[SEG_BITS:0] - {coarse_n[0], {SEG_BITS{1'b0}}};
    end
endmodule

// File: rtl/seg_dac_therm.sv
// Count to thermometer lines, filled from line 0 upward.
module seg_dac_therm #(
    parameter int CNT_W = 4,
    parameter int LINES = 16
) (
    input  logic [CNT_W-1:0] count,
    output logic [LINES-1:0] lines
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign lines[g] = (32'(count) > g);
    end
endmodule

// File: rtl/seg_dac_splitter.sv
module seg_dac_splitter #(
    parameter int IN_W     = seg_dac_splitter_pkg::DEF_IN_W,
    parameter int SEG_BITS = seg_dac_splitter_pkg::DEF_SEG_BITS
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic [IN_W-1:0]                     in_code,
    output logic [(1 << (IN_W-SEG_BITS))-1:0]   coarse_therm,
    output logic [(1 << (SEG_BITS+1))-1:0]      fine_therm
);
    localparam int CW           = IN_W - SEG_BITS;
    localparam int FW           = SEG_BITS + 1;
    localparam int COARSE_LINES = 1 << CW;
    localparam int FINE_LINES   = 1 << FW;

    logic [SEG_BITS-1:0]     acc_q;
    logic [SEG_BITS-1:0]     acc_d;
    logic [CW-1:0]           coarse_n;
    logic [FW-1:0]           fine_n;
    logic [COARSE_LINES-1:0] coarse_lines;
    logic [FINE_LINES-1:0]   fine_lines;

    seg_dac_requant #(.IN_W(IN_W), .SEG_BITS(SEG_BITS)) u_requant (
        .sample   (in_code),
        .acc_q    (acc_q),
        .coarse_n (coarse_n),
        .fine_n   (fine_n),
        .acc_d    (acc_d)
    );

    seg_dac_therm #(.CNT_W(CW), .LINES(COARSE_LINES)) u_coarse_enc (
        .count (coarse_n),
        .lines (coarse_lines)
    );

    seg_dac_therm #(.CNT_W(FW), .LINES(FINE_LINES)) u_fine_enc (
        .count (fine_n),
        .lines (fine_lines)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q        <= '0;
            coarse_therm <= '0;
            fine_therm   <= '0;
        end else if (in_valid) begin
            acc_q        <= acc_d;
            coarse_therm <= coarse_lines;
            fine_therm   <= fine_lines;
        end
    end
endmodule

// File: rtl/seg_dac_splitter_chk.sv
module seg_dac_splitter_chk #(
    parameter int IN_W     = seg_dac_splitter_pkg::DEF_IN_W,
    parameter int SEG_BITS = seg_dac_splitter_pkg::DEF_SEG_BITS
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              in_valid,
    input logic [IN_W-1:0]                   in_code,
    input logic [(1 << (IN_W-SEG_BITS))-1:0] coarse_therm,
    input logic [(1 << (SEG_BITS+1))-1:0]    fine_therm
);
    localparam int CL     = 1 << (IN_W - SEG_BITS);
    localparam int FL     = 1 << (SEG_BITS + 1);
    localparam int WEIGHT = 1 << SEG_BITS;

    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (coarse_therm == '0 && fine_therm == '0));

    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (primed && !$past(in_valid)) |-> ($stable(coarse_therm) && $stable(fine_therm)));

    p_sum_exact_r4: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(in_valid)) |->
            (WEIGHT * $countones(coarse_therm) + $countones(fine_therm) == int'($past(in_code))));

    p_coarse_therm_r5: assert property (@(posedge clk) disable iff (rst)
        ((coarse_therm & (coarse_therm + 1'b1)) == '0) && !coarse_therm[CL-1]);

    p_fine_therm_r6: assert property (@(posedge clk) disable iff (rst)
        ((fine_therm & (fine_therm + 1'b1)) == '0) && !fine_therm[FL-1]);
endmodule

bind seg_dac_splitter seg_dac_splitter_chk #(.IN_W(IN_W), .SEG_BITS(SEG_BITS)) u_chk (.*);

// File: tb/seg_dac_splitter_test.sv
module seg_dac_splitter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_code = '0;
    logic [15:0] coarse_therm;
    logic [7:0]  fine_therm;

    int checks = 0;
    int fails  = 0;
    int acc_m  = 0;
    int exp_c  = 0;
    int exp_f  = 0;
    int last_x = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seg_dac_splitter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm)
    );

    function automatic logic [15:0] cvec(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [7:0] fvec(input int n);
        return 8'((32'd1 << n) - 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Model of R7 and R8
    task automatic model_step(input int x);
        int s;
        s = x + acc_m - 3;
        if (s < 0) begin
            exp_c = 0;
            acc_m = 0;
        end else begin
            exp_c = s / 4;
            acc_m = s % 4;
        end
        exp_f  = x - 4 * exp_c;
        last_x = x;
    endtask

    task automatic send(input int x, input bit v);
        @(negedge clk);
        in_code  = 6'(x);
        in_valid = v;
        #2;
        chk(coarse_therm == cvec(exp_c) && fine_therm == fvec(exp_f),
            "R2 outputs early", int'(coarse_therm), int'(cvec(exp_c)));
        if (v) model_step(x);
        @(posedge clk);
        #1;
        chk(coarse_therm == cvec(exp_c), v ? "R5 R7 R8 coarse" : "R3 coarse hold",
            int'(coarse_therm), int'(cvec(exp_c)));
        chk(fine_therm == fvec(exp_f), v ? "R6 fine" : "R3 fine hold",
            int'(fine_therm), int'(fvec(exp_f)));
        chk(4 * $countones(coarse_therm) + $countones(fine_therm) == last_x, "R4 sum",
            4 * $countones(coarse_therm) + $countones(fine_therm), last_x);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        acc_m = 0; exp_c = 0; exp_f = 0; last_x = 0;
        chk(coarse_therm == '0 && fine_therm == '0, "R1 reset clear",
            int'(coarse_therm), 0);
    endtask

    task automatic steady_run(input int x);
        int csum;
        int fsum;
        csum = 0;
        fsum = 0;
        for (int i = 0; i < 4; i++) send(x, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send(x, 1'b1);
            csum += $countones(coarse_therm);
            fsum += $countones(fine_therm);
        end
        chk(csum == x - 3, "R9 coarse average", csum, x - 3);
        chk(fsum == 12, "R9 fine average", fsum, 12);
    endtask

    initial begin
        do_reset();
        // R1: first sample after reset uses a zero accumulator: 5 -> C=0, F=5
        send(5, 1'b1);
        chk($countones(fine_therm) == 5, "R1 zero accumulator", $countones(fine_therm), 5);
        // clamp corners (R8)
        send(0, 1'b1);
        send(2, 1'b1);
        send(1, 1'b1);
        send(63, 1'b1);
        send(63, 1'b1);
        send(3, 1'b1);
        // R3: rejected samples leave everything alone
        send(40, 1'b0);
        send(17, 1'b0);
        send(9, 1'b1);
        steady_run(27);
        steady_run(62);
        steady_run(3);
        // mid-run reset clears the accumulator (R1)
        send(38, 1'b1);
        do_reset();
        send(6, 1'b1);
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int x;
            bit v;
            x = int'($urandom_range(0, 63));
            if ($urandom_range(0, 9) == 0) x = ($urandom_range(0, 1) != 0) ? 63 : int'($urandom_range(0, 2));
            v = ($urandom_range(0, 3) != 0);
            send(x, v);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule